// File: doc/BRIEF.md
# SMT Hypervisor Doorbell Dispatcher

This block holds one pending hypervisor doorbell bit for each hardware thread of a multi-threaded core, and routes doorbell messages into those bits. A send request presents a 64-bit operand. The operand carries a message type, a two-bit broadcast selector and a 14-bit target processor tag. The block compares the tag with the processor ID of every thread. It then raises the pending bit of the matching thread. When broadcast applies and some thread matches, it raises the bits of all threads in the core instead.

The broadcast selector has two modes. The whole-core mode always reaches every thread. The subcore mode reaches every thread only while the single-partition mode input is high; otherwise it behaves like a directed send. A clear request, using the same operand, lowers the pending bit of the thread that issues it. Both kinds of request are dropped unless the type field holds the server doorbell code. Interrupt delivery, partition-tag checking and routing between cores are left to the surrounding logic.

Top module: `dbell_dispatch`

## Requirements
- R1: While reset is low, and on the first edge after it is released, every pending bit is 0.
- R2: A send or a clear acts only when operand bits 31:27 equal 5. With any other value in those bits, the request leaves every pending bit unchanged.
- R3: A directed send (selector value 0) raises exactly the pending bits of threads whose ID equals operand bits 13:0. The bit changes on the first rising edge at which the send strobe is sampled high, and not before that edge.
- R4: With selector operand bits 26:25 equal to 2 (whole core), a send whose tag matches any thread raises the pending bit of every thread.
- R5: With selector value 1 (subcore), a send raises every thread's bit when the single-partition input is 1, and only the matching thread's bit when it is 0.
- R6: Selector values 0 and 3 never broadcast; only the matching thread is raised.
- R7: A send whose tag matches no thread ID changes nothing, whatever the selector value.
- R8: Operand bits 63:32 and 24:14 have no effect on routing.
- R9: A valid clear lowers only the pending bit of the thread named by the clear index. An index at or above the thread count changes nothing.
- R10: Pending bits stay set until cleared. When a send and a clear address the same thread in the same cycle, the bit ends up set.
- R11: In a one-thread configuration, a broadcast send behaves as a directed send: it raises the bit only on a tag match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 64 | Message operand: type, selector and tag |
| send_i | input | 1 | Send strobe |
| clear_i | input | 1 | Clear strobe |
| clear_tid_i | input | IDX_W | Index of the thread issuing the clear |
| single_part_i | input | 1 | Single-partition mode; widens subcore broadcast |
| thread_id_i | input | NTHREADS*14 | Processor ID of each thread, thread 0 in the low bits |
| pending_o | output | NTHREADS | Pending doorbell bit of each thread |

## Verification
The bench sweeps all four selector values against both partition modes, with each thread and one absent tag as the target. A design that treated the subcore mode as an unconditional broadcast, or that broadcast on a tag miss, would light extra bits in that sweep. Every non-server type is tried for both sends and clears, which catches a decoder that reads the wrong type bits. Same-cycle send-plus-clear, clear indices outside the thread range and a one-thread core are driven as separate cases; a design that let the clear win, or that wrapped the index, would show the wrong pending pattern.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int DB_OP_W       = 64;
    localparam int DB_TAG_W      = 14;
    localparam int DB_TYPE_LSB   = 27;
    localparam int DB_TYPE_W     = 5;
    localparam int DB_SEL_LSB    = 25;
    localparam int DB_SEL_W      = 2;
    localparam int DB_SERVER_TYP = 5;

    typedef enum logic [DB_SEL_W-1:0] {
        SEL_DIRECT = 2'd0,
        SEL_SUBCORE = 2'd1,
        SEL_CORE   = 2'd2,
        SEL_RSVD   = 2'd3
    } bcast_sel_e;

    typedef struct packed {
        logic                type_ok;
        logic                bcast;
        logic [DB_TAG_W-1:0] tag;
    } dbell_dec_t;

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
    import dbell_pkg::*;
#(
    parameter int OP_W = DB_OP_W
) (
    input  logic [OP_W-1:0] op_i,
    input  logic            single_part_i,
    output dbell_dec_t      dec_o
);

    bcast_sel_e sel;
    logic       unused_bits;

    always_comb begin
        sel           = bcast_sel_e'(op_i[DB_SEL_LSB +: DB_SEL_W]);
        dec_o.type_ok = (op_i[DB_TYPE_LSB +: DB_TYPE_W] == DB_TYPE_W'(DB_SERVER_TYP));
        dec_o.tag     = op_i[DB_TAG_W-1:0];
        unique case (sel)
            SEL_CORE:    dec_o.bcast = 1'b1;
            SEL_SUBCORE: dec_o.bcast = single_part_i;
            default:     dec_o.bcast = 1'b0;
        endcase
    end

    // Partition tag and upper operand half play no part in routing.
    assign unused_bits = ^{op_i[OP_W-1:DB_TYPE_LSB+DB_TYPE_W], op_i[DB_SEL_LSB-1:DB_TAG_W]};

endmodule

// File: rtl/dbell_match.sv
module dbell_match
    import dbell_pkg::*;
#(
    parameter int NTHREADS = 4
) (
    input  logic [NTHREADS*DB_TAG_W-1:0] thread_id_i,
    input  logic [DB_TAG_W-1:0]          tag_i,
    output logic [NTHREADS-1:0]          hit_o
);

    for (genvar i = 0; i < NTHREADS; i++) begin : g_cmp
        assign hit_o[i] = (thread_id_i[i*DB_TAG_W +: DB_TAG_W] == tag_i);
    end

endmodule

// File: rtl/dbell_fanout.sv
module dbell_fanout #(
    parameter int NTHREADS = 4
) (
    input  logic                send_ok_i,
    input  logic                bcast_i,
    input  logic [NTHREADS-1:0] hit_i,
    output logic [NTHREADS-1:0] set_o
);

    if (NTHREADS == 1) begin : g_single
        logic unused_bcast;
        assign unused_bcast = bcast_i;
        assign set_o = send_ok_i ? hit_i : '0;
    end else begin : g_multi
        always_comb begin
            if (!send_ok_i)
                set_o = '0;
            else if (bcast_i && (|hit_i))
                set_o = '1;
            else
                set_o = hit_i;
        end
    end

endmodule

// File: rtl/dbell_clrmask.sv
module dbell_clrmask #(
    parameter int NTHREADS = 4,
    parameter int IDX_W    = 2
) (
    input  logic                clear_ok_i,
    input  logic [IDX_W-1:0]    tid_i,
    output logic [NTHREADS-1:0] clr_o
);

    for (genvar i = 0; i < NTHREADS; i++) begin : g_dec
        assign clr_o[i] = clear_ok_i && (tid_i == IDX_W'(i));
    end

endmodule

// File: rtl/dbell_dispatch.sv
module dbell_dispatch
    import dbell_pkg::*;
#(
    parameter int NTHREADS = 4,
    parameter int OP_W     = DB_OP_W,
    localparam int IDX_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [OP_W-1:0]              op_i,
    input  logic                         send_i,
    input  logic                         clear_i,
    input  logic [IDX_W-1:0]             clear_tid_i,
    input  logic                         single_part_i,
    input  logic [NTHREADS*DB_TAG_W-1:0] thread_id_i,
    output logic [NTHREADS-1:0]          pending_o
);

    typedef struct packed {
        logic [NTHREADS-1:0] pend;
    } state_t;

    state_t              st_d, st_q;
    dbell_dec_t          dec;
    logic [NTHREADS-1:0] hit;
    logic [NTHREADS-1:0] set_mask;
    logic [NTHREADS-1:0] clr_mask;

    dbell_decode #(.OP_W(OP_W)) u_dec (
        .op_i          (op_i),
        .single_part_i (single_part_i),
        .dec_o         (dec)
    );

    dbell_match #(.NTHREADS(NTHREADS)) u_match (
        .thread_id_i (thread_id_i),
        .tag_i       (dec.tag),
        .hit_o       (hit)
    );

    dbell_fanout #(.NTHREADS(NTHREADS)) u_fan (
        .send_ok_i (send_i && dec.type_ok),
        .bcast_i   (dec.bcast),
        .hit_i     (hit),
        .set_o     (set_mask)
    );

    dbell_clrmask #(.NTHREADS(NTHREADS), .IDX_W(IDX_W)) u_clr (
        .clear_ok_i (clear_i && dec.type_ok),
        .tid_i      (clear_tid_i),
        .clr_o      (clr_mask)
    );

    always_comb begin
        st_d      = st_q;
        // set applied after clear so a same-cycle send wins
        st_d.pend = (st_q.pend & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pending_o = st_q.pend;

    // ---------------- assertions ----------------
    p_bad_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((send_i || clear_i) && op_i[DB_TYPE_LSB +: DB_TYPE_W] != DB_TYPE_W'(DB_SERVER_TYP))
        |=> $stable(pending_o));

    p_hit_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (send_i && op_i[DB_TYPE_LSB +: DB_TYPE_W] == DB_TYPE_W'(DB_SERVER_TYP))
        |=> ((pending_o & $past(hit)) == $past(hit)));

    p_core_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (send_i && op_i[DB_TYPE_LSB +: DB_TYPE_W] == DB_TYPE_W'(DB_SERVER_TYP)
         && op_i[DB_SEL_LSB +: DB_SEL_W] == 2'd2 && (|hit))
        |=> (&pending_o));

    p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (send_i && !clear_i && hit == '0) |=> $stable(pending_o));

    p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !send_i) |=> ((pending_o & $past(clr_mask)) == '0));

    p_clr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_mask));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((pending_o & $past(pending_o)) == $past(pending_o)));

endmodule

// File: tb/tb_dbell_dispatch.sv
module tb_dbell_dispatch;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 3;
    localparam int IW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [63:0]       op = '0;
    logic              send = 1'b0, clr = 1'b0, sp = 1'b0;
    logic [IW-1:0]     tid = '0;
    logic [NT*14-1:0]  ids;
    logic [NT-1:0]     pend;
    logic              send1 = 1'b0, clr1 = 1'b0;
    logic [0:0]        tid1 = '0;
    logic [13:0]       id1 = 14'h123;
    logic [0:0]        pend1;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbell_dispatch #(.NTHREADS(NT)) dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .send_i(send), .clear_i(clr),
        .clear_tid_i(tid), .single_part_i(sp), .thread_id_i(ids), .pending_o(pend)
    );

    dbell_dispatch #(.NTHREADS(1)) dut_one (
        .clk(clk), .rst_n(rst_n), .op_i(op), .send_i(send1), .clear_i(clr1),
        .clear_tid_i(tid1), .single_part_i(sp), .thread_id_i(id1), .pending_o(pend1)
    );

    function automatic logic [13:0] tid_of(int i);
        return 14'h0A0 + 14'(i * 37);
    endfunction

    function automatic logic [63:0] mk_op(int ty, int sel, logic [13:0] tag, int salt);
        logic [63:0] o;
        o        = '0;
        o[63:32] = 32'(salt) * 32'h9E3779B1;
        o[24:14] = 11'(salt * 13 + 5);
        o[13:0]  = tag;
        o[26:25] = 2'(sel);
        o[31:27] = 5'(ty);
        return o;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic step(logic s, logic c, logic [IW-1:0] t, logic [63:0] o,
                        logic s1, logic c1, logic [0:0] t1);
        @(negedge clk);
        send = s; clr = c; tid = t; op = o;
        send1 = s1; clr1 = c1; tid1 = t1;
        @(posedge clk);
        #1;
        send = 1'b0; clr = 1'b0; send1 = 1'b0; clr1 = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < NT; i++)
            step(1'b0, 1'b1, IW'(i), mk_op(5, 0, '0, i), 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int salt;
        for (int i = 0; i < NT; i++) ids[i*14 +: 14] = tid_of(i);
        salt = 1;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 8'(pend), 8'h0);
        check("R1 in reset one-thread", 8'(pend1), 8'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after release", 8'(pend), 8'h0);

        // R3 R4 R5 R6 R7 R8: selector x partition mode x target sweep
        for (int sel = 0; sel < 4; sel++) begin
            for (int m = 0; m < 2; m++) begin
                for (int t = 0; t <= NT; t++) begin
                    logic [13:0]   tag;
                    logic [NT-1:0] hitv, expv;
                    logic          bc;
                    string         lbl;
                    clear_all();
                    sp   = m[0];
                    tag  = (t < NT) ? tid_of(t) : 14'h3FFF;
                    hitv = (t < NT) ? NT'(1 << t) : '0;
                    bc   = (sel == 2) || (sel == 1 && m == 1);
                    expv = (hitv == '0) ? '0 : (bc ? '1 : hitv);
                    step(1'b1, 1'b0, '0, mk_op(5, sel, tag, salt), 1'b0, 1'b0, 1'b0);
                    salt++;
                    if (t == NT)       lbl = "R7 no match";
                    else if (sel == 2) lbl = "R4 core";
                    else if (sel == 1) lbl = "R5 subcore";
                    else               lbl = "R6 directed R3 R8";
                    check(lbl, 8'(pend), 8'(expv));
                end
            end
        end
        sp = 1'b0;

        // R3 timing: no change before the edge, change right after it
        clear_all();
        @(negedge clk);
        send = 1'b1; op = mk_op(5, 0, tid_of(2), 77);
        #1;
        check("R3 before edge", 8'(pend), 8'h0);
        @(posedge clk);
        #1;
        send = 1'b0;
        check("R3 after edge", 8'(pend), 8'b100);

        // R2: every non-server type ignored for send
        clear_all();
        for (int ty = 0; ty < 32; ty++) begin
            if (ty != 5) begin
                step(1'b1, 1'b0, '0, mk_op(ty, 2, tid_of(0), ty), 1'b0, 1'b0, 1'b0);
                check("R2 send bad type", 8'(pend), 8'h0);
            end
        end
        step(1'b1, 1'b0, '0, mk_op(5, 2, tid_of(1), 9), 1'b0, 1'b0, 1'b0);
        check("R4 core set all", 8'(pend), 8'b111);
        // R2: every non-server type ignored for clear
        for (int ty = 0; ty < 32; ty++) begin
            if (ty != 5) begin
                step(1'b0, 1'b1, IW'(ty % NT), mk_op(ty, 0, '0, ty), 1'b0, 1'b0, 1'b0);
                check("R2 clear bad type", 8'(pend), 8'b111);
            end
        end

        // R9: clear only the issuing thread, out-of-range index does nothing
        step(1'b0, 1'b1, 2'd1, mk_op(5, 0, '0, 3), 1'b0, 1'b0, 1'b0);
        check("R9 clear thread1", 8'(pend), 8'b101);
        step(1'b0, 1'b1, 2'd3, mk_op(5, 0, '0, 4), 1'b0, 1'b0, 1'b0);
        check("R9 clear index out of range", 8'(pend), 8'b101);
        step(1'b0, 1'b1, 2'd0, mk_op(5, 0, '0, 5), 1'b0, 1'b0, 1'b0);
        check("R9 clear thread0", 8'(pend), 8'b100);

        // R10: sticky, send beats clear on the same thread
        step(1'b1, 1'b0, '0, mk_op(5, 0, 14'h3FFF, 6), 1'b0, 1'b0, 1'b0);
        check("R10 hold", 8'(pend), 8'b100);
        step(1'b1, 1'b1, 2'd0, mk_op(5, 0, tid_of(0), 7), 1'b0, 1'b0, 1'b0);
        check("R10 same-thread send wins", 8'(pend), 8'b101);
        step(1'b1, 1'b1, 2'd2, mk_op(5, 0, tid_of(1), 8), 1'b0, 1'b0, 1'b0);
        check("R10 send one clear other", 8'(pend), 8'b011);

        // R11: one-thread core
        step(1'b0, 1'b0, '0, mk_op(5, 0, '0, 0), 1'b0, 1'b1, 1'b0);
        check("R11 cleared", 8'(pend1), 8'h0);
        step(1'b0, 1'b0, '0, mk_op(5, 2, 14'h124, 1), 1'b1, 1'b0, 1'b0);
        check("R11 broadcast miss", 8'(pend1), 8'h0);
        sp = 1'b1;
        step(1'b0, 1'b0, '0, mk_op(5, 1, 14'h123, 2), 1'b1, 1'b0, 1'b0);
        check("R11 subcore hit", 8'(pend1), 8'h1);
        sp = 1'b0;
        step(1'b0, 1'b0, '0, mk_op(5, 0, '0, 3), 1'b0, 1'b1, 1'b1);
        check("R11 R9 index out of range", 8'(pend1), 8'h1);
        step(1'b0, 1'b0, '0, mk_op(5, 2, 14'h123, 4), 1'b1, 1'b0, 1'b0);
        check("R11 core hit", 8'(pend1), 8'h1);

        // R1: reset again with bits set
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", 8'(pend), 8'h0);
        check("R1 mid-run reset one-thread", 8'(pend1), 8'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule